// File: doc/BRIEF.md
# Branch and Call Program-Counter Sequencer

This block owns the program counter of a small processor that fetches 16-bit instruction words from a byte-addressed space. Each cycle it looks at the word fetched from the address on `pc_o` and decides the next address. Two control-flow forms are recognised. The first is a short relative branch taken only when the zero flag is set. The second is a two-word absolute subroutine call that records a return address on a hardware stack. A call can also capture a snapshot of the working, status and bank-select registers.

Every other word simply moves the PC on by one word. A taken branch costs one extra bubble cycle. A call always spends two cycles, one for each of its words. `flush_o` tells the fetch path that the sequential word stream is being abandoned.

Top module: `pc_seq`

## Requirements
- R1: A synchronous active-high reset sets `pc_o`, `tos_o`, the three shadow outputs and `stk_ovf_o` to zero and holds `flush_o` low. After reset the next word is decoded as a fresh instruction.
- R2: A word whose bits 15:8 equal 0xE0 is a zero-conditional branch. Bits 7:0 hold a two's-complement count n, from -128 to 127. When `zero_i` is 1, the PC becomes PC + 2 + 2n, taken modulo 2^21.
- R3: A branch word seen while `zero_i` is 0 advances the PC by 2 in a single cycle. The word that follows is decoded in the very next cycle.
- R4: The cycle after a taken branch is a bubble. In that cycle the presented word is ignored, even if it is a call or a branch. The PC holds its value, and `flush_o` is high for that cycle only.
- R5: A word whose bits 15:9 equal 1110110 is the first word of a call. Bit 8 is the save flag and bits 7:0 are target bits 7:0. That cycle advances the PC by 2 and pushes PC + 4, the address after both call words, so `tos_o` shows it from the next cycle.
- R6: The cycle after a call's first word always takes the presented word as the second call word. Its bits 11:0 are target bits 19:8. At the end of that cycle the PC becomes the 20-bit target shifted left by one. `flush_o` is high during that second cycle only.
- R7: On a call first word with the save flag set to 1, the values on `wreg_i`, `status_i` and `bsr_i` are captured into `ws_o`, `statuss_o` and `bsrs_o`. With the save flag at 0, the three shadow outputs keep their previous values.
- R8: The return stack holds `STK_DEPTH` (31) entries. A push when it is already full sets `stk_ovf_o`, which stays set until reset. Such a push leaves `tos_o` and the stored entries unchanged.
- R9: Any other word, including a 0xF-prefixed word seen outside a call, advances the PC by 2 in one cycle. Such a word leaves `flush_o` low.
- R10: Bit 0 of `pc_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word fetched from `pc_o` |
| zero_i | input | 1 | Zero flag from the datapath |
| wreg_i | input | REG_W | Working register value |
| status_i | input | REG_W | Status register value |
| bsr_i | input | REG_W | Bank-select register value |
| pc_o | output | 21 | Program counter (byte address) |
| tos_o | output | 21 | Top entry of the return stack, zero when empty |
| flush_o | output | 1 | Sequential stream abandoned this cycle |
| ws_o | output | REG_W | Shadow of the working register |
| statuss_o | output | REG_W | Shadow of the status register |
| bsrs_o | output | REG_W | Shadow of the bank-select register |
| stk_ovf_o | output | 1 | Sticky return-stack overflow |

## Verification
The hardest condition to reach from the ports is the full-stack push. With no pop path, the stack must be filled by 31 back-to-back calls before a thirty-second call can expose the overflow flag and show that the top entry stays frozen. The stimulus chains calls whose second words point at scattered targets, with the save flag alternating. It then issues one extra call and checks that `tos_o` still holds the return address of the thirty-first. A second subtle case is a call word placed in a taken branch's bubble cycle. It must cause neither a push nor a shadow capture.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_CALL2 = 2'd1,
    ST_BUB   = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_BRZ   = 2'd1,
    OP_CALL  = 2'd2
  } op_kind_t;

  localparam int IW = 16;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic [IW-1:0]   word_i,
  output op_kind_t        kind_o,
  output logic [PC_W-1:0] disp_o,
  output logic            save_o,
  output logic [7:0]      klo_o,
  output logic [11:0]     khi_o
);
  localparam int EXT_W = PC_W - 9;

  always_comb begin
    if (word_i[15:8] == 8'hE0)
      kind_o = OP_BRZ;
    else if (word_i[15:9] == 7'b1110110)
      kind_o = OP_CALL;
    else
      kind_o = OP_OTHER;
  end

  // byte displacement 2n, sign-extended to the PC width
  assign disp_o = {{EXT_W{word_i[7]}}, word_i[7:0], 1'b0};
  assign save_o = word_i[8];
  assign klo_o  = word_i[7:0];
  assign khi_o  = word_i[11:0];
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int DEPTH = 31,
  parameter int AW    = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] tos_o,
  output logic          ovf_o
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam logic [SP_W-1:0] FULL = SP_W'(DEPTH);

  logic [AW-1:0]   mem [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic            full;

  assign full = (sp_q == FULL);

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_i && !full)
      mem[sp_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      ovf_o <= 1'b0;
    end else if (push_i) begin
      if (full)
        ovf_o <= 1'b1;
      else
        sp_q <= sp_q + 1'b1;
    end
  end

  assign tos_o = (sp_q == '0) ? '0 : mem[sp_q - 1'b1];
endmodule

// File: rtl/pcs_shadow.sv
module pcs_shadow #(
  parameter int N  = 3,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_i,
  input  logic [N-1:0][DW-1:0] d_i,
  output logic [N-1:0][DW-1:0] q_o
);
  logic [DW-1:0] r_q [N];

  for (genvar g = 0; g < N; g++) begin : g_sh
    always_ff @(posedge clk) begin
      if (rst)
        r_q[g] <= '0;
      else if (cap_i)
        r_q[g] <= d_i[g];
    end
    assign q_o[g] = r_q[g];
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pcs_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int STK_DEPTH = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [15:0]         instr_i,
  input  logic                zero_i,
  input  logic [REG_W-1:0]    wreg_i,
  input  logic [REG_W-1:0]    status_i,
  input  logic [REG_W-1:0]    bsr_i,
  output logic [20:0]         pc_o,
  output logic [20:0]         tos_o,
  output logic                flush_o,
  output logic [REG_W-1:0]    ws_o,
  output logic [REG_W-1:0]    statuss_o,
  output logic [REG_W-1:0]    bsrs_o,
  output logic                stk_ovf_o
);
  localparam int KW   = 20;
  localparam int PC_W = KW + 1;
  localparam int NSH  = 3;

  seq_state_t      state_q;
  logic [PC_W-1:0] pc_q;
  logic [7:0]      klo_q;
  logic            flush_q;

  op_kind_t        kind;
  logic [PC_W-1:0] disp;
  logic            save_bit;
  logic [7:0]      klo;
  logic [11:0]     khi;

  logic            in_run;
  logic            push;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] pc_seq_nx;

  logic [NSH-1:0][REG_W-1:0] sh_d;
  logic [NSH-1:0][REG_W-1:0] sh_q;

  pcs_decode #(.PC_W(PC_W)) u_dec (
    .word_i (instr_i),
    .kind_o (kind),
    .disp_o (disp),
    .save_o (save_bit),
    .klo_o  (klo),
    .khi_o  (khi)
  );

  assign in_run    = (state_q == ST_RUN);
  assign push      = in_run && (kind == OP_CALL);
  assign pc_seq_nx = pc_q + PC_W'(2);
  assign ret_addr  = pc_q + PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      pc_q    <= '0;
      klo_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          pc_q <= pc_seq_nx;
          if (kind == OP_BRZ && zero_i) begin
            pc_q    <= pc_seq_nx + disp;
            state_q <= ST_BUB;
            flush_q <= 1'b1;
          end else if (kind == OP_CALL) begin
            klo_q   <= klo;
            state_q <= ST_CALL2;
            flush_q <= 1'b1;
          end
        end
        ST_CALL2: begin
          pc_q    <= {khi, klo_q, 1'b0};
          state_q <= ST_RUN;
        end
        ST_BUB: begin
          state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  pcs_stack #(.DEPTH(STK_DEPTH), .AW(PC_W)) u_stk (
    .clk    (clk),
    .rst    (rst),
    .push_i (push),
    .din_i  (ret_addr),
    .tos_o  (tos_o),
    .ovf_o  (stk_ovf_o)
  );

  assign sh_d[0] = wreg_i;
  assign sh_d[1] = status_i;
  assign sh_d[2] = bsr_i;

  pcs_shadow #(.N(NSH), .DW(REG_W)) u_sh (
    .clk   (clk),
    .rst   (rst),
    .cap_i (push && save_bit),
    .d_i   (sh_d),
    .q_o   (sh_q)
  );

  assign ws_o      = sh_q[0];
  assign statuss_o = sh_q[1];
  assign bsrs_o    = sh_q[2];
  assign pc_o      = pc_q;
  assign flush_o   = flush_q;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      instr_i,
  input logic             zero_i,
  input logic [1:0]       state_q,
  input logic [20:0]      pc_o,
  input logic             flush_o,
  input logic [REG_W-1:0] ws_o,
  input logic             stk_ovf_o
);
  localparam logic [1:0] S_RUN = 2'd0;
  localparam logic [1:0] S_C2  = 2'd1;
  localparam logic [1:0] S_BUB = 2'd2;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !flush_o && !stk_ovf_o));

  p_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RUN && instr_i[15:8] == 8'hE0 && !zero_i)
      |=> (pc_o == $past(pc_o) + 21'd2 && !flush_o));

  p_bubble_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BUB) |=> (pc_o == $past(pc_o)));

  p_flush_single_r4: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o);

  p_call2_flush_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_C2) |-> flush_o);

  p_shadow_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RUN && instr_i[15:9] == 7'b1110110 && !instr_i[8])
      |=> $stable(ws_o));

  p_no_overflow_clear_r8: assert property (@(posedge clk) disable iff (rst)
    stk_ovf_o |=> stk_ovf_o);

  p_pc_even_r10: assert property (@(posedge clk) disable iff (rst)
    !pc_o[0]);
endmodule

bind pc_seq pc_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr_i   (instr_i),
  .zero_i    (zero_i),
  .state_q   (state_q),
  .pc_o      (pc_o),
  .flush_o   (flush_o),
  .ws_o      (ws_o),
  .stk_ovf_o (stk_ovf_o)
);

// File: tb/sim_pc_seq.sv
`timescale 1ns/100ps
module sim_pc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_i = 16'h0000;
  logic        zero_i = 1'b0;
  logic [7:0]  wreg_i = 8'h00, status_i = 8'h00, bsr_i = 8'h00;
  logic [20:0] pc_o, tos_o;
  logic        flush_o, stk_ovf_o;
  logic [7:0]  ws_o, statuss_o, bsrs_o;

  always #2.5 clk = ~clk;

  pc_seq u0 (
    .clk(clk), .rst(rst), .instr_i(instr_i), .zero_i(zero_i),
    .wreg_i(wreg_i), .status_i(status_i), .bsr_i(bsr_i),
    .pc_o(pc_o), .tos_o(tos_o), .flush_o(flush_o),
    .ws_o(ws_o), .statuss_o(statuss_o), .bsrs_o(bsrs_o),
    .stk_ovf_o(stk_ovf_o)
  );

  typedef struct packed {
    logic [20:0] pc;
    logic [20:0] tos;
    logic        fl;
    logic        ov;
    logic [7:0]  ws;
    logic [7:0]  ss;
    logic [7:0]  bs;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;

  // reference model state
  logic [20:0] m_pc = '0;
  int          m_st = 0;
  logic [20:0] m_stk [31];
  int          m_sp = 0;
  logic        m_ov = 1'b0, m_fl = 1'b0;
  logic [7:0]  m_ws = '0, m_ss = '0, m_bs = '0, m_klo = '0;

  task automatic step(input logic [15:0] ins, input logic z,
                      input logic [7:0] w, input logic [7:0] s,
                      input logic [7:0] b, input logic r, input string tag);
    exp_t e;
    logic [20:0] ret;
    @(negedge clk);
    instr_i = ins; zero_i = z; wreg_i = w; status_i = s; bsr_i = b; rst = r;
    if (r) begin
      m_pc = '0; m_st = 0; m_sp = 0; m_ov = 0; m_fl = 0;
      m_ws = '0; m_ss = '0; m_bs = '0;
    end else begin
      case (m_st)
        0: begin
          if (ins[15:8] == 8'hE0) begin
            if (z) begin
              m_pc = m_pc + 21'd2 + {{12{ins[7]}}, ins[7:0], 1'b0};
              m_st = 2; m_fl = 1;
            end else begin
              m_pc = m_pc + 21'd2; m_fl = 0;
            end
          end else if (ins[15:9] == 7'b1110110) begin
            ret = m_pc + 21'd4;
            if (m_sp == 31) m_ov = 1;
            else begin m_stk[m_sp] = ret; m_sp++; end
            if (ins[8]) begin m_ws = w; m_ss = s; m_bs = b; end
            m_klo = ins[7:0];
            m_pc = m_pc + 21'd2; m_st = 1; m_fl = 1;
          end else begin
            m_pc = m_pc + 21'd2; m_fl = 0;
          end
        end
        1: begin m_pc = {ins[11:0], m_klo, 1'b0}; m_st = 0; m_fl = 0; end
        default: begin m_st = 0; m_fl = 0; end
      endcase
    end
    e.pc = m_pc; e.tos = (m_sp == 0) ? '0 : m_stk[m_sp-1];
    e.fl = m_fl; e.ov = m_ov; e.ws = m_ws; e.ss = m_ss; e.bs = m_bs;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic op(input logic [15:0] ins, input logic z, input string tag);
    step(ins, z, 8'h00, 8'h00, 8'h00, 1'b0, tag);
  endtask

  task automatic call(input logic [19:0] k, input logic s,
                      input logic [7:0] w, input logic [7:0] st,
                      input logic [7:0] b, input string tag);
    step({7'b1110110, s, k[7:0]}, 1'b0, w, st, b, 1'b0, tag);
    step({4'hF, k[19:8]}, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, tag);
  endtask

  // monitor: compare after every rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (pc_o !== e.pc) begin
        n_bad++; $display("FAIL %s pc_o act=%h exp=%h", t, pc_o, e.pc);
      end
      if (tos_o !== e.tos) begin
        n_bad++; $display("FAIL %s tos_o act=%h exp=%h", t, tos_o, e.tos);
      end
      if (flush_o !== e.fl) begin
        n_bad++; $display("FAIL %s flush_o act=%b exp=%b", t, flush_o, e.fl);
      end
      if (stk_ovf_o !== e.ov) begin
        n_bad++; $display("FAIL %s stk_ovf_o act=%b exp=%b", t, stk_ovf_o, e.ov);
      end
      if ({ws_o, statuss_o, bsrs_o} !== {e.ws, e.ss, e.bs}) begin
        n_bad++;
        $display("FAIL %s shadows act=%h %h %h exp=%h %h %h", t,
                 ws_o, statuss_o, bsrs_o, e.ws, e.ss, e.bs);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) step(16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R1_reset");
    // R9: plain words, including a stray second-call-word pattern
    op(16'h0123, 1'b0, "R9_other");
    op(16'hF123, 1'b1, "R9_other");
    op(16'hE100, 1'b1, "R9_other");
    // R3: branch not taken
    op(16'hE005, 1'b0, "R3_not_taken");
    op(16'hE0FF, 1'b0, "R3_not_taken");
    // R2/R4: taken branch, bubble presents a call word which must be ignored
    op(16'hE003, 1'b1, "R2_taken_fwd");
    step(16'hED55, 1'b0, 8'hAA, 8'hBB, 8'hCC, 1'b0, "R4_bubble_ignores");
    op(16'h0000, 1'b0, "R4_after_bubble");
    op(16'hE07F, 1'b1, "R2_taken_max");
    op(16'hE0AA, 1'b1, "R4_bubble_ignores");
    op(16'hE080, 1'b1, "R2_taken_min");
    op(16'h0000, 1'b0, "R4_bubble");
    op(16'hE0FF, 1'b1, "R2_taken_minus1");
    op(16'h0000, 1'b0, "R4_bubble");
    // R5/R6/R7: call with save, then without save
    call(20'hABCDE, 1'b1, 8'h11, 8'h22, 8'h33, "R5_R6_R7_call_save");
    op(16'h1234, 1'b0, "R9_at_target");
    call(20'h00040, 1'b0, 8'h44, 8'h55, 8'h66, "R7_call_nosave");
    op(16'hE002, 1'b1, "R2_after_call");
    op(16'h0000, 1'b0, "R4_bubble");
    // R8: fill the stack (2 used so far), then overflow
    for (int i = 0; i < 29; i++)
      call(20'(i * 4099 + 17), 1'(i % 2), 8'(i), 8'(i + 1), 8'(i + 2), "R8_fill");
    call(20'h12345, 1'b1, 8'h77, 8'h88, 8'h99, "R8_overflow");
    call(20'h54321, 1'b0, 8'h01, 8'h02, 8'h03, "R8_overflow_sticky");
    op(16'h0000, 1'b0, "R8_sticky");
    // R1: reset mid run
    step(16'h0000, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, "R1_reset");
    op(16'h0000, 1'b0, "R1_after_reset");
    call(20'h00010, 1'b1, 8'h5A, 8'hA5, 8'h3C, "R5_after_reset");
    @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule